// File: doc/BRIEF.md
# Branching Instruction Fetch Unit

This block owns the program counter of a single-cycle processor. In every cycle it presents the 32-bit instruction word stored at the current PC, which comes from a small internal instruction memory. It also computes the address for the next cycle. Control logic outside the block supplies two indicators, "this is a conditional branch" and "this is a jump", and the ALU supplies its zero flag. The block forms the branch-taken decision itself by ANDing the branch indicator with the zero flag.

The next address is chosen from three candidates. The sequential address is PC+4. The branch target is PC+4 plus the sign-extended 16-bit immediate of the current instruction, scaled to bytes. The jump target takes the upper four bits of PC+4 and appends the 26-bit target field of the instruction, scaled to bytes. The instruction memory is written through a simple synchronous word port, which a loader or testbench uses to place a program before execution starts.

Top module: `fetch_unit`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, the PC becomes 0 at that edge. Reset takes priority over jump and branch requests.
- R2: `instr` shows, without a clock delay, the memory word whose index is PC bits [IDX_W+1:2], where IDX_W = log2(MEM_WORDS).
- R3: When `jump` is 0 and the pair (`branch`, `zero`) is not (1,1), the PC advances by 4 at the next rising edge. This includes the cases branch=1 with zero=0, and branch=0 with zero=1.
- R4: When `branch` and `zero` are both 1 and `jump` is 0, the next PC is PC+4 plus instr[15:0] sign-extended to 30 bits and shifted left by 2. The sum wraps modulo 2^32.
- R5: When `jump` is 1, the next PC is {(PC+4)[31:28], instr[25:0], 2'b00}. This holds whatever the values of `branch` and `zero`.
- R6: When `load_en` is 1 at a rising edge, `load_word` is stored at word index `load_addr`. The new value appears on `instr` from that edge on whenever the PC indexes that word.
- R7: PC bits above IDX_W+1 play no part in the memory lookup, so addresses that differ only in those bits fetch the same word.
- R8: PC bits [1:0] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| branch | input | 1 | Current instruction is a conditional branch |
| jump | input | 1 | Current instruction is a jump |
| zero | input | 1 | ALU zero flag for the current instruction |
| load_en | input | 1 | Instruction memory write enable |
| load_addr | input | IDX_W | Word index to write |
| load_word | input | 32 | Word to write |
| instr | output | 32 | Instruction word at the current PC |
| pc | output | 32 | Current program counter |

## Verification
The bench builds the block with MEM_WORDS = 64, which keeps the indexed window at 256 bytes. With that window, a jump to 0x104 lands on an aliased copy of word 1. A branch with the most negative offset wraps the PC below zero into 0xFFFE_0118 and still fetches word 6. A jump taken from that high address then keeps the upper nibble F. Because of this, aliasing (R7), 32-bit wraparound (R4) and upper-bit carry-over (R5) can all be reached within a dozen cycles.

// File: rtl/fetch_unit.sv
module fetch_unit #(
  parameter int MEM_WORDS = 256,
  localparam int IDX_W = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branch,
  input  logic              jump,
  input  logic              zero,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_addr,
  input  logic [31:0]       load_word,
  output logic [31:0]       instr,
  output logic [31:0]       pc
);

  logic [31:0] mem [MEM_WORDS];

  logic [31:0] seq_pc, br_pc, jmp_pc, next_pc;
  logic        taken;

  assign instr  = mem[pc[IDX_W+1:2]];
  assign taken  = branch & zero;
  assign seq_pc = pc + 32'd4;
  assign br_pc  = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_pc = {seq_pc[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (jump)       next_pc = jmp_pc;
    else if (taken) next_pc = br_pc;
    else            next_pc = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (load_en) mem[load_addr] <= load_word;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= next_pc;
  end

  assert_reset_R1: assert property (@(posedge clk) $past(rst) |-> pc == 32'd0);

  assert_seq_R3: assert property (@(posedge clk) disable iff (rst)
    (!jump && !(branch && zero)) |=> pc == $past(pc) + 32'd4);

  assert_branch_R4: assert property (@(posedge clk) disable iff (rst)
    (!jump && branch && zero) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  assert_jump_R5: assert property (@(posedge clk) disable iff (rst)
    jump |=> pc[27:0] == {$past(instr[25:0]), 2'b00});

  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    load_en |=> mem[$past(load_addr)] == $past(load_word));

  assert_align_R8: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

endmodule

// File: tb/test_fetch_unit.sv
module test_fetch_unit;
  localparam int WORDS = 64;
  localparam int IW = $clog2(WORDS);
  localparam int NSTEP = 12;

  logic clk = 1'b0;
  logic rst, branch, jump, zero, load_en;
  logic [IW-1:0] load_addr;
  logic [31:0] load_word, instr, pc;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fetch_unit #(.MEM_WORDS(WORDS)) i_fetch_unit (
    .clk(clk), .rst(rst), .branch(branch), .jump(jump), .zero(zero),
    .load_en(load_en), .load_addr(load_addr), .load_word(load_word),
    .instr(instr), .pc(pc)
  );

  // control bits: {branch, jump, zero}
  localparam logic [2:0] CTL [NSTEP] = '{
    3'b000, 3'b100, 3'b001, 3'b101, 3'b101, 3'b111,
    3'b010, 3'b000, 3'b101, 3'b101, 3'b010, 3'b000};
  localparam logic [31:0] CUR_I [NSTEP] = '{
    32'hA500_0000, 32'hA500_0001, 32'hA500_0002, 32'h0000_0005,
    32'h1234_FFFC, 32'h0800_0020, 32'h0C00_0041, 32'hA500_0001,
    32'hA500_0002, 32'h0000_8000, 32'h0800_0020, 32'h0C00_0041};
  localparam logic [31:0] NXT_PC [NSTEP] = '{
    32'h0000_0004, 32'h0000_0008, 32'h0000_000C, 32'h0000_0024,
    32'h0000_0018, 32'h0000_0080, 32'h0000_0104, 32'h0000_0108,
    32'h0000_0114, 32'hFFFE_0118, 32'hF000_0080, 32'hF000_0084};
  localparam string TAG [NSTEP] = '{
    "R3", "R3", "R3", "R4", "R4", "R5",
    "R5 R7", "R3 R7", "R4 R7", "R4", "R5 R7", "R3 R7"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_word(input int idx, input logic [31:0] w);
    load_en = 1'b1; load_addr = IW'(idx); load_word = w;
    @(posedge clk); @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; branch = 1'b0; jump = 1'b0; zero = 1'b0;
    load_en = 1'b0; load_addr = '0; load_word = '0;
    @(negedge clk);
    for (int k = 0; k < WORDS; k++) write_word(k, 32'hA500_0000 | k);
    write_word(3,  32'h0000_0005);
    write_word(9,  32'h1234_FFFC);
    write_word(6,  32'h0800_0020);
    write_word(32, 32'h0C00_0041);
    write_word(5,  32'h0000_8000);
    check("R1 reset pc", pc, 32'h0);
    check("R2 reset instr", instr, 32'hA500_0000);
    rst = 1'b0;

    for (int s = 0; s < NSTEP; s++) begin
      check({TAG[s], " R2 instr"}, instr, CUR_I[s]);
      {branch, jump, zero} = CTL[s];
      @(posedge clk); @(negedge clk);
      check({TAG[s], " R8 next pc"}, pc, NXT_PC[s]);
    end
    {branch, jump, zero} = 3'b000;

    // R6: write the word the next PC will fetch while stepping
    load_en = 1'b1; load_addr = IW'(34); load_word = 32'h5A5A_0000;
    @(posedge clk); @(negedge clk);
    load_en = 1'b0;
    check("R6 pc", pc, 32'hF000_0088);
    check("R6 new word fetched", instr, 32'h5A5A_0000);

    // R1: reset wins over a jump and a taken branch
    rst = 1'b1; {branch, jump, zero} = 3'b111;
    @(posedge clk); @(negedge clk);
    check("R1 reset over jump", pc, 32'h0);
    check("R1 R2 instr after reset", instr, 32'hA500_0000);
    rst = 1'b0; {branch, jump, zero} = 3'b000;
    @(posedge clk); @(negedge clk);
    check("R3 after reset", pc, 32'h4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule